// File: doc/BRIEF.md
# Memory Protection Controller Register File

This block is the configuration and status register file for a memory protection controller that splits memory into fixed-size blocks. Each block has one security bit. The bits are packed 32 to a word in a lookup table. Software reaches the table through a single data window. An index register picks which table word the window shows. The index can step forward by itself after each full-word window access, and it wraps at the table size. That lets software stream the whole table with consecutive accesses.

The host side is an APB-style bus with a 32-bit data path. It accepts byte, halfword and word accesses. Read data is combinational during the access phase. Writes and side effects take effect at the clock edge that ends the access phase. The block also holds:
- a control word with a lockdown bit, which freezes the control, table and interrupt-enable registers until reset;
- interrupt status, set, clear and enable registers, which drive a level interrupt;
- two fault-information registers, which read as zero because nothing in this block fills them.

A separate read port gives a downstream address checker the table word and the security bit for any block number.

Top module: `mpc_cfg_regs`

## Requirements
- R1: After reset, control reads 0x00000100, index reads 0, interrupt status reads 0, interrupt enable reads 1, both info registers read 0, every table word reads 0, and `irq` is low.
- R2: Control (offset 0x00) keeps only bit 4 (security response select), bit 8 (auto-step enable) and bit 31 (lockdown). All other bits read as zero.
- R3: Offset 0x10 reads the parameter LUT_WORDS. Offset 0x14 reads BLK_LOG2 − 5, so the block size in bytes is 1 << (value + 5).
- R4: Window accesses at offset 0x1C read or write the table word selected by the index register at offset 0x18.
- R5: A full-word window access with control bit 8 set advances the index by one. The index after LUT_WORDS − 1 is 0.
- R6: A byte or halfword window access never advances the index. With control bit 8 clear, no window access advances it.
- R7: A write to the index register stores the written 32-bit value modulo LUT_WORDS.
- R8: `psize` 0 is a byte, 1 is a halfword, and 2 or 3 is a word. The byte lane comes from `paddr[1:0]` and the data sits in its lane of `pwdata`. A sub-word write to control, index or window merges into the current value before any other processing.
- R9: While control bit 31 is set, writes to control, window and interrupt enable are ignored, and a window write does not advance the index. The index and interrupt set/clear registers stay writable. Only reset clears lockdown.
- R10: Writing 1 to bit 0 at offset 0x34 sets interrupt status. Writing 1 to bit 0 at offset 0x24 clears it. Writes with bit 0 at zero do nothing. Interrupt enable (offset 0x28) keeps bit 0 only.
- R11: `irq` is high exactly when status (offset 0x20) and enable are both 1. It follows a changing write by one clock edge.
- R12: Offsets outside the map read as zero and ignore writes. Info registers at 0x2C and 0x30 read as zero.
- R13: `chk_word` is table word `chk_blk[BLK_W-1:5]`, and `chk_secure` is bit `chk_blk[4:0]` of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register bus select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address |
| psize | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| pwdata | input | 32 | Write data, lane-aligned |
| prdata | output | 32 | Read data during the access phase, else zero |
| irq | output | 1 | Level interrupt |
| chk_blk | input | BLK_W | Block number queried by the address checker |
| chk_word | output | 32 | Table word holding that block |
| chk_secure | output | 1 | Security bit of that block |

## Verification
A wrong index shows on the next window read as a value from the wrong table word. It also shows at once when the index register is read, so the bench reads the index back after every stepping or non-stepping access. A lost lockdown shows on the first control or enable read after a blocked write. A wrong interrupt status or enable shows on `irq` one edge after the write that should have changed it. Table corruption shows on `chk_word` combinationally, with no bus access needed.

// File: rtl/mpc_regs_pkg.sv
package mpc_regs_pkg;
  localparam logic [11:0] OFS_CTRL   = 12'h000;
  localparam logic [11:0] OFS_LIMIT  = 12'h010;
  localparam logic [11:0] OFS_GEOM   = 12'h014;
  localparam logic [11:0] OFS_IDX    = 12'h018;
  localparam logic [11:0] OFS_WIN    = 12'h01C;
  localparam logic [11:0] OFS_ISTAT  = 12'h020;
  localparam logic [11:0] OFS_ICLR   = 12'h024;
  localparam logic [11:0] OFS_IEN    = 12'h028;
  localparam logic [11:0] OFS_INFO_A = 12'h02C;
  localparam logic [11:0] OFS_INFO_B = 12'h030;
  localparam logic [11:0] OFS_ISET   = 12'h034;

  localparam logic [31:0] CTRL_KEEP  = 32'h8000_0110;
  localparam logic [31:0] CTRL_RESET = 32'h0000_0100;
  localparam int          CTRL_LOCK  = 31;
  localparam int          CTRL_STEP  = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } xfer_size_e;

  typedef struct packed {
    logic ctrl;
    logic limit;
    logic geom;
    logic idx;
    logic win;
    logic istat;
    logic iclr;
    logic ien;
    logic info;
    logic iset;
  } reg_hit_t;
endpackage

// File: rtl/mpc_bus_decode.sv
module mpc_bus_decode
  import mpc_regs_pkg::*;
(
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [1:0]  psize,
  output logic        acc_rd,
  output logic        acc_wr,
  output reg_hit_t    hit,
  output logic [31:0] lane_mask,
  output logic        full_word
);
  logic [11:0] word_addr;
  xfer_size_e  sz;

  assign acc_rd    = psel && penable && !pwrite;
  assign acc_wr    = psel && penable && pwrite;
  assign word_addr = {paddr[11:2], 2'b00};
  assign sz        = xfer_size_e'(psize);
  assign full_word = (sz == SZ_WORD) || (sz == SZ_WIDE);

  always_comb begin
    hit       = '0;
    hit.ctrl  = (word_addr == OFS_CTRL);
    hit.limit = (word_addr == OFS_LIMIT);
    hit.geom  = (word_addr == OFS_GEOM);
    hit.idx   = (word_addr == OFS_IDX);
    hit.win   = (word_addr == OFS_WIN);
    hit.istat = (word_addr == OFS_ISTAT);
    hit.iclr  = (word_addr == OFS_ICLR);
    hit.ien   = (word_addr == OFS_IEN);
    hit.info  = (word_addr == OFS_INFO_A) || (word_addr == OFS_INFO_B);
    hit.iset  = (word_addr == OFS_ISET);
  end

  always_comb begin
    case (sz)
      SZ_BYTE: lane_mask = 32'h0000_00FF << {paddr[1:0], 3'b000};
      SZ_HALF: lane_mask = 32'h0000_FFFF << {paddr[1], 4'b0000};
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  end
endmodule

// File: rtl/mpc_lut_store.sv
module mpc_lut_store #(
  parameter int LUT_WORDS = 8,
  localparam int IDX_W    = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1,
  localparam int BLK_W    = IDX_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_we,
  input  logic [31:0]      idx_wval,
  input  logic             word_we,
  input  logic [31:0]      word_wval,
  input  logic             step,
  output logic [IDX_W-1:0] idx_o,
  output logic [31:0]      word_o,
  input  logic [BLK_W-1:0] chk_blk,
  output logic [31:0]      chk_word,
  output logic             chk_secure
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LUT_WORDS - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [31:0]      mem_q [LUT_WORDS];
  logic [IDX_W-1:0] chk_sel;

  always_comb begin
    idx_d = idx_q;
    if (idx_we)
      idx_d = IDX_W'(idx_wval % 32'(LUT_WORDS));
    else if (step)
      idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                idx_q <= '0;
    else if (idx_we || step)   idx_q <= idx_d;
  end

  for (genvar g = 0; g < LUT_WORDS; g++) begin : g_word
    logic hit_w;
    assign hit_w = word_we && (idx_q == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mem_q[g] <= '0;
      else if (hit_w) mem_q[g] <= word_wval;
    end
  end

  assign idx_o      = idx_q;
  assign word_o     = mem_q[idx_q];
  assign chk_sel    = chk_blk[BLK_W-1:5];
  assign chk_word   = (32'(chk_sel) < LUT_WORDS) ? mem_q[chk_sel] : '0;
  assign chk_secure = chk_word[chk_blk[4:0]];

  // R7: index never leaves the table
  a_r7_idx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    32'(idx_q) < LUT_WORDS);
  // R5: stepping from the last word wraps to zero
  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    step && !idx_we && idx_q == LAST |=> idx_q == '0);
  // R6: without a step or index write the index holds
  a_r6_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !idx_we |=> $stable(idx_q));
endmodule

// File: rtl/mpc_irq_ctrl.sv
module mpc_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic en_we,
  input  logic en_val,
  output logic stat_o,
  output logic en_o,
  output logic irq_o
);
  logic stat_q, stat_d, en_q, en_d;

  always_comb begin
    stat_d = stat_q;
    if (clr_req)      stat_d = 1'b0;
    else if (set_req) stat_d = 1'b1;
    en_d = en_we ? en_val : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      en_q   <= 1'b1;
    end else begin
      if (set_req || clr_req) stat_q <= stat_d;
      if (en_we)              en_q   <= en_d;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_o  = stat_q && en_q;

  // R11: a set with enable on raises the line after one edge
  a_r11_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    set_req && !clr_req && en_q && !en_we |=> irq_o);
  // R10: a clear drops the line after one edge
  a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !irq_o);
  // R11: disabling masks the line after one edge
  a_r11_mask_drops: assert property (@(posedge clk) disable iff (!rst_n)
    en_we && !en_val |=> !irq_o);
endmodule

// File: rtl/mpc_cfg_regs.sv
module mpc_cfg_regs
  import mpc_regs_pkg::*;
#(
  parameter int LUT_WORDS = 8,
  parameter int BLK_LOG2  = 8,
  localparam int IDX_W    = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1,
  localparam int BLK_W    = IDX_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [11:0]      paddr,
  input  logic [1:0]       psize,
  input  logic [31:0]      pwdata,
  output logic [31:0]      prdata,
  output logic             irq,
  input  logic [BLK_W-1:0] chk_blk,
  output logic [31:0]      chk_word,
  output logic             chk_secure
);
  localparam logic [31:0] GEOM_VAL  = 32'(BLK_LOG2 - 5);
  localparam logic [31:0] LIMIT_VAL = 32'(LUT_WORDS);

  logic        acc_rd, acc_wr, full_word, locked;
  reg_hit_t    hit;
  logic [31:0] lane_mask, wmasked;
  logic [31:0] ctrl_q, ctrl_d;
  logic        ctrl_we;
  logic [IDX_W-1:0] idx;
  logic [31:0] idx_ext, cur_word, idx_merged, word_merged;
  logic        win_we, step;
  logic        stat, en;
  logic [31:0] rd_mux;

  mpc_bus_decode i_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .psize(psize), .acc_rd(acc_rd), .acc_wr(acc_wr), .hit(hit),
    .lane_mask(lane_mask), .full_word(full_word)
  );

  assign locked      = ctrl_q[CTRL_LOCK];
  assign wmasked     = pwdata & lane_mask;
  assign idx_ext     = 32'(idx);
  assign idx_merged  = (idx_ext & ~lane_mask) | wmasked;
  assign word_merged = (cur_word & ~lane_mask) | wmasked;

  assign ctrl_we = acc_wr && hit.ctrl && !locked;
  assign ctrl_d  = ((ctrl_q & ~lane_mask) | wmasked) & CTRL_KEEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RESET;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  assign win_we = acc_wr && hit.win && !locked;
  assign step   = hit.win && full_word && ctrl_q[CTRL_STEP] && (acc_rd || win_we);

  mpc_lut_store #(.LUT_WORDS(LUT_WORDS)) i_lut (
    .clk(clk), .rst_n(rst_n),
    .idx_we(acc_wr && hit.idx), .idx_wval(idx_merged),
    .word_we(win_we), .word_wval(word_merged), .step(step),
    .idx_o(idx), .word_o(cur_word),
    .chk_blk(chk_blk), .chk_word(chk_word), .chk_secure(chk_secure)
  );

  mpc_irq_ctrl i_irq (
    .clk(clk), .rst_n(rst_n),
    .set_req(acc_wr && hit.iset && wmasked[0]),
    .clr_req(acc_wr && hit.iclr && wmasked[0]),
    .en_we(acc_wr && hit.ien && !locked), .en_val(wmasked[0]),
    .stat_o(stat), .en_o(en), .irq_o(irq)
  );

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      hit.ctrl:  rd_mux = ctrl_q;
      hit.limit: rd_mux = LIMIT_VAL;
      hit.geom:  rd_mux = GEOM_VAL;
      hit.idx:   rd_mux = idx_ext;
      hit.win:   rd_mux = cur_word;
      hit.istat: rd_mux = {31'b0, stat};
      hit.ien:   rd_mux = {31'b0, en};
      default:   rd_mux = '0;
    endcase
  end

  assign prdata = acc_rd ? rd_mux : '0;

  // R9: once locked, control never changes before reset
  a_r9_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(ctrl_q));
  // R2: reserved control bits stay zero
  a_r2_ctrl_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~CTRL_KEEP) == '0);
endmodule

// File: tb/test_mpc_cfg_regs.sv
`timescale 1ns/1ps
module test_mpc_cfg_regs;
  localparam int BLK_W = 8;

  logic        clk = 1'b0;
  logic        rst_n, psel, penable, pwrite;
  logic [11:0] paddr;
  logic [1:0]  psize;
  logic [31:0] pwdata, prdata, chk_word;
  logic        irq, chk_secure;
  logic [BLK_W-1:0] chk_blk;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  mpc_cfg_regs #(.LUT_WORDS(8), .BLK_LOG2(8)) i_mpc_cfg_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .psize(psize), .pwdata(pwdata), .prdata(prdata), .irq(irq),
    .chk_blk(chk_blk), .chk_word(chk_word), .chk_secure(chk_secure)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; psel = 0; penable = 0; pwrite = 0;
    paddr = '0; psize = 2'd2; pwdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d);
    psel = 1; penable = 0; pwrite = 1; paddr = a; psize = sz; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] sz, output logic [31:0] d);
    psel = 1; penable = 0; pwrite = 0; paddr = a; psize = sz;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    chk("R1 irq", {31'b0, irq}, 0);
    rd(12'h000, 2, v); chk("R1 ctrl", v, 32'h100);
    rd(12'h018, 2, v); chk("R1 idx", v, 0);
    rd(12'h020, 2, v); chk("R1 stat", v, 0);
    rd(12'h028, 2, v); chk("R1 en", v, 1);
    rd(12'h02C, 2, v); chk("R1 info_a", v, 0);
    rd(12'h030, 2, v); chk("R1 info_b", v, 0);
    for (int i = 0; i < 8; i++) begin
      rd(12'h01C, 2, v); chk("R1 lut", v, 0);
    end
  endtask

  task automatic t_ctrl_mask();
    logic [31:0] v;
    do_reset();
    wr(12'h000, 2, 32'h7FFF_FFFF); rd(12'h000, 2, v); chk("R2 ctrl mask", v, 32'h110);
    wr(12'h001, 0, 32'h0000_0000); rd(12'h000, 2, v); chk("R8 ctrl byte1", v, 32'h010);
    wr(12'h002, 1, 32'h0000_0000); rd(12'h000, 2, v); chk("R8 ctrl half hi", v, 32'h010);
    wr(12'h000, 0, 32'h0000_0100); rd(12'h000, 2, v); chk("R8 ctrl byte0", v, 32'h000);
  endtask

  task automatic t_geometry();
    logic [31:0] v;
    do_reset();
    rd(12'h010, 2, v); chk("R3 limit", v, 8);
    rd(12'h014, 2, v); chk("R3 geom", v, 3);
  endtask

  task automatic t_lut_walk();
    logic [31:0] v;
    do_reset();
    for (int i = 0; i < 8; i++) wr(12'h01C, 2, 32'h0101_0101 * i + 32'hA0);
    rd(12'h018, 2, v); chk("R5 wrapped idx", v, 0);
    wr(12'h01C, 2, 32'hDEAD_0000);
    rd(12'h018, 2, v); chk("R5 idx after wrap write", v, 1);
    wr(12'h018, 2, 0);
    for (int i = 0; i < 8; i++) begin
      rd(12'h01C, 2, v);
      chk("R4 lut readback", v, (i == 0) ? 32'hDEAD_0000 : 32'h0101_0101 * i + 32'hA0);
    end
    rd(12'h018, 2, v); chk("R5 idx after read sweep", v, 0);
  endtask

  task automatic t_subword();
    logic [31:0] v;
    do_reset();
    wr(12'h018, 2, 3);
    wr(12'h01E, 1, 32'hBEEF_0000);
    rd(12'h018, 2, v); chk("R6 half no step", v, 3);
    wr(12'h01C, 0, 32'h0000_0012);
    rd(12'h018, 2, v); chk("R6 byte no step", v, 3);
    wr(12'h000, 2, 0);
    rd(12'h01C, 2, v); chk("R8 lut merged", v, 32'hBEEF_0012);
    rd(12'h018, 2, v); chk("R6 step off", v, 3);
    wr(12'h019, 0, 32'h0000_0100);
    rd(12'h018, 2, v); chk("R8 idx byte1 merge", v, 3);
  endtask

  task automatic t_idx_mod();
    logic [31:0] v;
    do_reset();
    wr(12'h018, 2, 13); rd(12'h018, 2, v); chk("R7 idx 13", v, 5);
    wr(12'h018, 2, 8);  rd(12'h018, 2, v); chk("R7 idx 8", v, 0);
    wr(12'h018, 2, 7);  rd(12'h018, 2, v); chk("R7 idx 7", v, 7);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    do_reset();
    wr(12'h034, 2, 1); chk("R11 irq on set", {31'b0, irq}, 1);
    rd(12'h020, 2, v); chk("R10 stat set", v, 1);
    wr(12'h028, 2, 0); chk("R11 irq masked", {31'b0, irq}, 0);
    wr(12'h028, 2, 32'hFFFF_FFFF); rd(12'h028, 2, v); chk("R10 en bit0 only", v, 1);
    chk("R11 irq unmasked", {31'b0, irq}, 1);
    wr(12'h024, 2, 2); chk("R10 clear bit1 ignored", {31'b0, irq}, 1);
    wr(12'h024, 2, 1); chk("R10 irq cleared", {31'b0, irq}, 0);
    rd(12'h020, 2, v); chk("R10 stat cleared", v, 0);
    wr(12'h034, 2, 2); rd(12'h020, 2, v); chk("R10 set bit1 ignored", v, 0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    do_reset();
    wr(12'h01C, 2, 32'h55);
    wr(12'h000, 2, 32'h8000_0000); rd(12'h000, 2, v); chk("R9 lock set", v, 32'h8000_0000);
    wr(12'h000, 2, 32'h100); rd(12'h000, 2, v); chk("R9 ctrl frozen", v, 32'h8000_0000);
    wr(12'h018, 2, 0); rd(12'h018, 2, v); chk("R9 idx writable", v, 0);
    wr(12'h01C, 2, 32'h77); rd(12'h01C, 2, v); chk("R9 lut frozen", v, 32'h55);
    wr(12'h028, 2, 0); rd(12'h028, 2, v); chk("R9 en frozen", v, 1);
    wr(12'h034, 2, 1); chk("R9 set still works", {31'b0, irq}, 1);
    do_reset();
    rd(12'h000, 2, v); chk("R9 reset unlocks", v, 32'h100);
    wr(12'h000, 2, 32'h8000_0100);
    wr(12'h01C, 2, 32'h99);
    rd(12'h018, 2, v); chk("R9 blocked write no step", v, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    do_reset();
    wr(12'h040, 2, 32'hFFFF_FFFF);
    rd(12'h040, 2, v); chk("R12 unmapped read", v, 0);
    rd(12'hFD0, 2, v); chk("R12 high region read", v, 0);
    rd(12'h000, 2, v); chk("R12 ctrl untouched", v, 32'h100);
    wr(12'h02C, 2, 32'h1234); rd(12'h02C, 2, v); chk("R12 info zero", v, 0);
  endtask

  task automatic t_checker();
    do_reset();
    wr(12'h018, 2, 5);
    wr(12'h01C, 2, 32'h0000_0008);
    chk_blk = 8'(5 * 32 + 3); #1;
    chk("R13 word", chk_word, 32'h8);
    chk("R13 bit set", {31'b0, chk_secure}, 1);
    chk_blk = 8'(5 * 32 + 2); #1;
    chk("R13 bit clear", {31'b0, chk_secure}, 0);
    chk_blk = 8'd3; #1;
    chk("R13 other word", chk_word, 0);
  endtask

  initial begin
    chk_blk = '0;
    t_reset();
    t_ctrl_mask();
    t_geometry();
    t_lut_walk();
    t_subword();
    t_idx_mod();
    t_irq();
    t_lock();
    t_unmapped();
    t_checker();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule